// File: doc/BRIEF.md
# Real-Time Scheduler Command Unit

This block is the control core of a hardware task scheduler for a real-time system. A processor writes commands to it through a single command port. Each command carries an operation code, a task number and a data word. The block keeps a table of per-task parameters addressed directly by task number. It checks every command against that table and against its own state. If the command is legal, it updates the table and sends insert and remove requests to an external ready queue and an external sleep queue. Those queues are separate blocks and are not part of this design.

Every command takes a fixed number of cycles, however many tasks exist. Most commands finish in one cycle. The two commands that need a read-modify-write or a staged queue move take two cycles, and a busy flag covers the second cycle. The unit also holds the active scheduling discipline, which can be changed while the system runs. The discipline decides which sort key goes with each ready-queue insert. The unit also holds the current-task register, which follows the head of the ready queue while scheduling is running. A one-cycle pulse marks each change of the selected task.

Top module: `sched_cmd_unit`

## Requirements
- R1: A command is taken on a rising edge where `cmd_wr_i` is 1 and `busy_o` is 0. The operation codes are: 0 create, 1 modify, 2 timed sleep, 3 period sleep, 4 yield, 5 suspend, 6 resume, 7 delete, 8 configure, 9 run and 10 stop. The queue requests of a one-cycle command are on the outputs for the single cycle that follows the accepting edge.
- R2: Create uses this data layout: priority in bits [3:0], period in [15:4], worst-case time in [27:16], task type in bit 28 and preemptable in bit 29. On an unused task number it stores these fields, marks the task used and ready, and issues a ready insert with the discipline key. On a used number it is rejected.
- R3: Operation codes 11 to 15 are rejected. Any task command other than create on an unused task number is also rejected. A rejected command issues no queue request and changes no state.
- R4: Modify selects a field with data bits [31:30] (0 priority, 1 period, 2 worst-case time) and takes the new value from the low data bits. For a ready task it issues a ready remove in the first cycle and a ready insert with the new key in the second. For a suspended task it only rewrites the field. Selector 3 is rejected.
- R5: `busy_o` is 1 only in the single cycle after a modify or timed sleep is accepted.
- R6: A command written while `busy_o` is 1 is rejected and not executed. The command already in progress still completes.
- R7: Timed sleep issues a ready remove, then one cycle later a sleep insert with the tick count from data bits [11:0]. Period sleep issues, in one cycle, a ready remove and a sleep insert whose tick count is the stored period. Yield does the same with a tick count of 1. All three are rejected on a suspended task.
- R8: Suspend issues a ready remove and a sleep remove and marks the task suspended. Resume issues a ready insert with a key computed from the stored fields and marks the task ready. Suspend on a suspended task is rejected, and so is resume on a ready task.
- R9: Delete issues a ready remove and a sleep remove and frees the task number, so that a later create on that number is accepted.
- R10: Configure takes the discipline from data bits [1:0]. Value 0 is fixed priority (key = priority). Value 1 is earliest deadline (key = tick count + period, modulo 2^12). Value 2 is rate monotonic (key = period). Value 3 is rejected and keeps the previous discipline. The tick count is the number of `tick_i` pulses seen since reset.
- R11: While running, on each edge where `rq_head_vld_i` is 1, the current task loads `rq_head_tid_i`. `switch_o` is 1 for one cycle if the loaded value differs from the previous one, or if no task was current before.
- R12: After reset, the unit is stopped, the discipline is fixed priority, and busy, error, current-valid, switch and all queue requests are 0. While the unit is stopped, the current task holds its value and `switch_o` stays 0.
- R13: `err_o` is updated on every edge where `cmd_wr_i` is 1: it is set to 1 if the command was rejected and 0 if it was accepted. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_op_i | input | 4 | Operation code |
| cmd_tid_i | input | 4 | Target task number |
| cmd_data_i | input | 32 | Command data word |
| tick_i | input | 1 | System time tick pulse |
| rq_head_vld_i | input | 1 | Ready queue holds a task |
| rq_head_tid_i | input | 4 | Task at the ready queue head |
| busy_o | output | 1 | Second cycle of a two-cycle command |
| err_o | output | 1 | Last written command was rejected |
| rq_ins_o | output | 1 | Ready queue insert request |
| rq_rem_o | output | 1 | Ready queue remove request |
| rq_tid_o | output | 4 | Task of the ready queue request |
| rq_key_o | output | 12 | Sort key for a ready insert |
| sq_ins_o | output | 1 | Sleep queue insert request |
| sq_rem_o | output | 1 | Sleep queue remove request |
| sq_tid_o | output | 4 | Task of the sleep queue request |
| sq_ticks_o | output | 12 | Sleep duration in ticks |
| disc_o | output | 2 | Active scheduling discipline |
| cur_vld_o | output | 1 | A current task is selected |
| cur_tid_o | output | 4 | Current task number |
| switch_o | output | 1 | Current task changed |

## Verification
Directed sequences take one task through every legal state change and then through every illegal one. The queue request pattern and the sleep duration show which command actually ran, and the error flag shows whether the unit rejected the command or executed it. Suspend followed by resume is repeated under each discipline after the tick count has moved, so the insert key shows whether the priority, the period or the deadline sum was used. A command placed in the busy cycle, followed by a probe command, shows whether the unit dropped that command or ran it. A long random mix of operation codes, task numbers and data words then reaches combinations the directed sequences miss, such as sleeping tasks being suspended or deleted.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [3:0] {
    OP_CREATE  = 4'd0,
    OP_MODIFY  = 4'd1,
    OP_SLEEP   = 4'd2,
    OP_SSLEEP  = 4'd3,
    OP_YIELD   = 4'd4,
    OP_SUSPEND = 4'd5,
    OP_RESUME  = 4'd6,
    OP_DELETE  = 4'd7,
    OP_CONFIG  = 4'd8,
    OP_RUN     = 4'd9,
    OP_STOP    = 4'd10
  } op_e;

  typedef enum logic [1:0] {
    DISC_PRIO = 2'd0,
    DISC_EDF  = 2'd1,
    DISC_RM   = 2'd2
  } disc_e;
endpackage

// File: rtl/sched_task_table.sv
// Per-task parameter storage: one synchronous write port, asynchronous read (LUT RAM).
module sched_task_table #(
  parameter int N_TASKS = 16,
  parameter int PRIO_W  = 4,
  parameter int TIME_W  = 12,
  localparam int ID_W   = $clog2(N_TASKS),
  localparam int ENT_W  = PRIO_W + 2*TIME_W + 2
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ID_W-1:0]   waddr_i,
  input  logic [PRIO_W-1:0] wprio_i,
  input  logic [TIME_W-1:0] wperiod_i,
  input  logic [TIME_W-1:0] wwcet_i,
  input  logic              wtype_i,
  input  logic              wpre_i,
  input  logic [ID_W-1:0]   raddr_i,
  output logic [PRIO_W-1:0] rprio_o,
  output logic [TIME_W-1:0] rperiod_o,
  output logic [TIME_W-1:0] rwcet_o,
  output logic              rtype_o,
  output logic              rpre_o
);
  logic [ENT_W-1:0] mem_q [N_TASKS];
  logic [ENT_W-1:0] rd_w;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= {wpre_i, wtype_i, wwcet_i, wperiod_i, wprio_i};
  end

  assign rd_w = mem_q[raddr_i];
  assign {rpre_o, rtype_o, rwcet_o, rperiod_o, rprio_o} = rd_w;
endmodule

// File: rtl/sched_task_flags.sv
// Used/suspended flags per task, kept in reset flops so legality checks need no RAM read.
module sched_task_flags #(
  parameter int N_TASKS = 16,
  localparam int ID_W   = $clog2(N_TASKS)
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               we_i,
  input  logic [ID_W-1:0]    waddr_i,
  input  logic               wused_i,
  input  logic               wsusp_i,
  output logic [N_TASKS-1:0] used_o,
  output logic [N_TASKS-1:0] susp_o
);
  for (genvar i = 0; i < N_TASKS; i++) begin : g_flag
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        used_o[i] <= 1'b0;
        susp_o[i] <= 1'b0;
      end else if (we_i && (waddr_i == ID_W'(i))) begin
        used_o[i] <= wused_i;
        susp_o[i] <= wsusp_i;
      end
    end
  end
endmodule

// File: rtl/sched_key_gen.sv
// Ready-queue sort key for the active discipline.
module sched_key_gen
  import sched_pkg::*;
#(
  parameter int PRIO_W = 4,
  parameter int TIME_W = 12
) (
  input  disc_e             disc_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [TIME_W-1:0] period_i,
  input  logic [TIME_W-1:0] now_i,
  output logic [TIME_W-1:0] key_o
);
  always_comb begin
    case (disc_i)
      DISC_EDF: key_o = now_i + period_i;
      DISC_RM:  key_o = period_i;
      default:  key_o = TIME_W'(prio_i);
    endcase
  end
endmodule

// File: rtl/sched_cmd_unit.sv
module sched_cmd_unit
  import sched_pkg::*;
#(
  parameter int N_TASKS = 16,
  parameter int PRIO_W  = 4,
  parameter int TIME_W  = 12,
  localparam int ID_W   = $clog2(N_TASKS),
  localparam int DATA_W = PRIO_W + 2*TIME_W + 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cmd_wr_i,
  input  logic [3:0]        cmd_op_i,
  input  logic [ID_W-1:0]   cmd_tid_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              tick_i,
  input  logic              rq_head_vld_i,
  input  logic [ID_W-1:0]   rq_head_tid_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              rq_ins_o,
  output logic              rq_rem_o,
  output logic [ID_W-1:0]   rq_tid_o,
  output logic [TIME_W-1:0] rq_key_o,
  output logic              sq_ins_o,
  output logic              sq_rem_o,
  output logic [ID_W-1:0]   sq_tid_o,
  output logic [TIME_W-1:0] sq_ticks_o,
  output logic [1:0]        disc_o,
  output logic              cur_vld_o,
  output logic [ID_W-1:0]   cur_tid_o,
  output logic              switch_o
);
  // Data word field positions
  localparam int PER_LSB = PRIO_W;
  localparam int WC_LSB  = PRIO_W + TIME_W;
  localparam int TYP_BIT = PRIO_W + 2*TIME_W;
  localparam int PRE_BIT = TYP_BIT + 1;
  localparam int SEL_MSB = DATA_W - 1;

  // State
  logic              busy_q, is_mod_q, err_q, run_q;
  logic [ID_W-1:0]   tid_q;
  logic [TIME_W-1:0] arg_q;
  logic [1:0]        sel_q;
  disc_e             disc_q, disc_n;
  logic [TIME_W-1:0] now_q;
  logic              cur_vld_q, switch_q;
  logic [ID_W-1:0]   cur_q;

  // Table and flags
  logic [N_TASKS-1:0] used_w, susp_w;
  logic [PRIO_W-1:0]  rd_prio;
  logic [TIME_W-1:0]  rd_period, rd_wcet;
  logic               rd_type, rd_pre;
  logic [ID_W-1:0]    act_tid;
  logic               tbl_we;
  logic [PRIO_W-1:0]  w_prio;
  logic [TIME_W-1:0]  w_period, w_wcet;
  logic               w_type, w_pre;
  logic               flag_we, flag_used, flag_susp;

  // Decode results
  logic              bad, go2, run_n;
  logic              rq_ins_n, rq_rem_n, sq_ins_n, sq_rem_n;
  logic [TIME_W-1:0] ticks_n, key_w;
  logic [PRIO_W-1:0] k_prio;
  logic [TIME_W-1:0] k_period;
  logic              t_used, t_susp;

  assign t_used = used_w[cmd_tid_i];
  assign t_susp = susp_w[cmd_tid_i];

  sched_task_table #(.N_TASKS(N_TASKS), .PRIO_W(PRIO_W), .TIME_W(TIME_W)) u_table (
    .clk_i    (clk_i),
    .we_i     (tbl_we),
    .waddr_i  (act_tid),
    .wprio_i  (w_prio),
    .wperiod_i(w_period),
    .wwcet_i  (w_wcet),
    .wtype_i  (w_type),
    .wpre_i   (w_pre),
    .raddr_i  (act_tid),
    .rprio_o  (rd_prio),
    .rperiod_o(rd_period),
    .rwcet_o  (rd_wcet),
    .rtype_o  (rd_type),
    .rpre_o   (rd_pre)
  );

  sched_task_flags #(.N_TASKS(N_TASKS)) u_flags (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .we_i   (flag_we),
    .waddr_i(act_tid),
    .wused_i(flag_used),
    .wsusp_i(flag_susp),
    .used_o (used_w),
    .susp_o (susp_w)
  );

  sched_key_gen #(.PRIO_W(PRIO_W), .TIME_W(TIME_W)) u_key (
    .disc_i  (disc_q),
    .prio_i  (k_prio),
    .period_i(k_period),
    .now_i   (now_q),
    .key_o   (key_w)
  );

  // Command decode: one pass per cycle, fixed work regardless of task count
  always_comb begin
    bad       = 1'b0;
    go2       = 1'b0;
    run_n     = run_q;
    disc_n    = disc_q;
    act_tid   = busy_q ? tid_q : cmd_tid_i;
    tbl_we    = 1'b0;
    flag_we   = 1'b0;
    flag_used = 1'b0;
    flag_susp = 1'b0;
    rq_ins_n  = 1'b0;
    rq_rem_n  = 1'b0;
    sq_ins_n  = 1'b0;
    sq_rem_n  = 1'b0;
    ticks_n   = '0;
    w_prio    = cmd_data_i[PRIO_W-1:0];
    w_period  = cmd_data_i[PER_LSB +: TIME_W];
    w_wcet    = cmd_data_i[WC_LSB +: TIME_W];
    w_type    = cmd_data_i[TYP_BIT];
    w_pre     = cmd_data_i[PRE_BIT];
    k_prio    = w_prio;
    k_period  = w_period;

    if (busy_q) begin
      // second cycle of a two-cycle command; any new write is refused
      bad = cmd_wr_i;
      if (is_mod_q) begin
        w_prio   = rd_prio;
        w_period = rd_period;
        w_wcet   = rd_wcet;
        w_type   = rd_type;
        w_pre    = rd_pre;
        case (sel_q)
          2'd0:    w_prio   = arg_q[PRIO_W-1:0];
          2'd1:    w_period = arg_q;
          default: w_wcet   = arg_q;
        endcase
        tbl_we   = 1'b1;
        k_prio   = w_prio;
        k_period = w_period;
        rq_ins_n = !susp_w[tid_q];
      end else begin
        sq_ins_n = 1'b1;
        ticks_n  = arg_q;
      end
    end else if (cmd_wr_i) begin
      if (cmd_op_i != OP_CREATE && cmd_op_i <= OP_DELETE && !t_used) begin
        bad = 1'b1;
      end else begin
        case (cmd_op_i)
          OP_CREATE: begin
            if (t_used) bad = 1'b1;
            else begin
              tbl_we    = 1'b1;
              flag_we   = 1'b1;
              flag_used = 1'b1;
              rq_ins_n  = 1'b1;
            end
          end
          OP_MODIFY: begin
            if (cmd_data_i[SEL_MSB -: 2] == 2'd3) bad = 1'b1;
            else begin
              go2      = 1'b1;
              rq_rem_n = !t_susp;
            end
          end
          OP_SLEEP: begin
            if (t_susp) bad = 1'b1;
            else begin
              go2      = 1'b1;
              rq_rem_n = 1'b1;
            end
          end
          OP_SSLEEP, OP_YIELD: begin
            if (t_susp) bad = 1'b1;
            else begin
              rq_rem_n = 1'b1;
              sq_ins_n = 1'b1;
              ticks_n  = (cmd_op_i == OP_YIELD) ? TIME_W'(1) : rd_period;
            end
          end
          OP_SUSPEND: begin
            if (t_susp) bad = 1'b1;
            else begin
              flag_we   = 1'b1;
              flag_used = 1'b1;
              flag_susp = 1'b1;
              rq_rem_n  = 1'b1;
              sq_rem_n  = 1'b1;
            end
          end
          OP_RESUME: begin
            if (!t_susp) bad = 1'b1;
            else begin
              flag_we   = 1'b1;
              flag_used = 1'b1;
              rq_ins_n  = 1'b1;
              k_prio    = rd_prio;
              k_period  = rd_period;
            end
          end
          OP_DELETE: begin
            flag_we  = 1'b1;
            rq_rem_n = 1'b1;
            sq_rem_n = 1'b1;
          end
          OP_CONFIG: begin
            if (cmd_data_i[1:0] == 2'd3) bad = 1'b1;
            else disc_n = disc_e'(cmd_data_i[1:0]);
          end
          OP_RUN:  run_n = 1'b1;
          OP_STOP: run_n = 1'b0;
          default: bad = 1'b1;
        endcase
      end
    end
  end

  // Registered state and outputs
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q     <= 1'b0;
      is_mod_q   <= 1'b0;
      tid_q      <= '0;
      arg_q      <= '0;
      sel_q      <= '0;
      err_q      <= 1'b0;
      run_q      <= 1'b0;
      disc_q     <= DISC_PRIO;
      now_q      <= '0;
      rq_ins_o   <= 1'b0;
      rq_rem_o   <= 1'b0;
      sq_ins_o   <= 1'b0;
      sq_rem_o   <= 1'b0;
      rq_tid_o   <= '0;
      sq_tid_o   <= '0;
      rq_key_o   <= '0;
      sq_ticks_o <= '0;
      cur_vld_q  <= 1'b0;
      cur_q      <= '0;
      switch_q   <= 1'b0;
    end else begin
      busy_q <= go2;
      if (go2) begin
        is_mod_q <= (cmd_op_i == OP_MODIFY);
        tid_q    <= cmd_tid_i;
        arg_q    <= cmd_data_i[TIME_W-1:0];
        sel_q    <= cmd_data_i[SEL_MSB -: 2];
      end
      if (cmd_wr_i) err_q <= bad;
      run_q  <= run_n;
      disc_q <= disc_n;
      if (tick_i) now_q <= now_q + TIME_W'(1);

      rq_ins_o   <= rq_ins_n;
      rq_rem_o   <= rq_rem_n;
      sq_ins_o   <= sq_ins_n;
      sq_rem_o   <= sq_rem_n;
      rq_tid_o   <= act_tid;
      sq_tid_o   <= act_tid;
      rq_key_o   <= key_w;
      sq_ticks_o <= ticks_n;

      if (run_q && rq_head_vld_i) begin
        cur_q     <= rq_head_tid_i;
        cur_vld_q <= 1'b1;
        switch_q  <= !cur_vld_q || (cur_q != rq_head_tid_i);
      end else begin
        switch_q  <= 1'b0;
      end
    end
  end

  assign busy_o    = busy_q;
  assign err_o     = err_q;
  assign disc_o    = disc_q;
  assign cur_vld_o = cur_vld_q;
  assign cur_tid_o = cur_q;
  assign switch_o  = switch_q;
endmodule

// File: rtl/sched_cmd_unit_chk.sv
module sched_cmd_unit_chk #(
  parameter int ID_W = 4
) (
  input logic            clk_i,
  input logic            rst_i,
  input logic            cmd_wr_i,
  input logic            busy_i,
  input logic            err_i,
  input logic            run_i,
  input logic            rq_ins_i,
  input logic            rq_rem_i,
  input logic            cur_vld_i,
  input logic [ID_W-1:0] cur_tid_i,
  input logic            switch_i
);
  assert_busy_single_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_i |=> !busy_i);

  assert_busy_write_rejected_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_wr_i && busy_i) |=> err_i);

  assert_err_holds_R13: assert property (@(posedge clk_i) disable iff (rst_i)
    !cmd_wr_i |=> $stable(err_i));

  assert_stop_no_switch_R12: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> !switch_i);

  assert_stop_holds_cur_R12: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> $stable(cur_tid_i));

  assert_switch_has_task_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    switch_i |-> cur_vld_i);

  assert_rq_one_request_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !(rq_ins_i && rq_rem_i));
endmodule

bind sched_cmd_unit sched_cmd_unit_chk #(.ID_W(ID_W)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .cmd_wr_i (cmd_wr_i),
  .busy_i   (busy_o),
  .err_i    (err_o),
  .run_i    (run_q),
  .rq_ins_i (rq_ins_o),
  .rq_rem_i (rq_rem_o),
  .cur_vld_i(cur_vld_o),
  .cur_tid_i(cur_tid_o),
  .switch_i (switch_o)
);

// File: tb/sched_cmd_unit_bench.sv
module sched_cmd_unit_bench;
  localparam int CLK_P = 10;
  localparam int NT = 16;
  localparam int IW = 4;
  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_wr = 1'b0;
  logic [3:0]    cmd_op = '0;
  logic [IW-1:0] cmd_tid = '0;
  logic [31:0]   cmd_data = '0;
  logic          tick = 1'b0;
  logic          head_vld = 1'b0;
  logic [IW-1:0] head_tid = '0;
  logic          busy, err, rq_ins, rq_rem, sq_ins, sq_rem, cur_vld, sw;
  logic [IW-1:0] rq_tid, sq_tid, cur_tid;
  logic [TW-1:0] rq_key, sq_ticks;
  logic [1:0]    disc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  bit          m_used [NT];
  bit          m_susp [NT];
  int          m_prio [NT];
  int          m_period [NT];
  int          m_disc = 0;
  logic [TW-1:0] m_now = '0;

  always #(CLK_P/2) clk = ~clk;

  sched_cmd_unit u_sched_cmd_unit (
    .clk_i(clk), .rst_i(rst), .cmd_wr_i(cmd_wr), .cmd_op_i(cmd_op),
    .cmd_tid_i(cmd_tid), .cmd_data_i(cmd_data), .tick_i(tick),
    .rq_head_vld_i(head_vld), .rq_head_tid_i(head_tid),
    .busy_o(busy), .err_o(err), .rq_ins_o(rq_ins), .rq_rem_o(rq_rem),
    .rq_tid_o(rq_tid), .rq_key_o(rq_key), .sq_ins_o(sq_ins), .sq_rem_o(sq_rem),
    .sq_tid_o(sq_tid), .sq_ticks_o(sq_ticks), .disc_o(disc),
    .cur_vld_o(cur_vld), .cur_tid_o(cur_tid), .switch_o(sw)
  );

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] exp_key(input int p, input int per);
    case (m_disc)
      1:       return m_now + TW'(per);
      2:       return TW'(per);
      default: return TW'(p);
    endcase
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0: return "R2";
      1: return "R4";
      2, 3, 4: return "R7";
      5, 6: return "R8";
      7: return "R9";
      8: return "R10";
      9, 10: return "R11";
      default: return "R3";
    endcase
  endfunction

  // Compare queue request outputs with the expected pattern; fields only when qualified.
  task automatic check_req(input string tag, input int tid, input bit ri, input bit rr,
                           input bit si, input bit sr, input logic [TW-1:0] key,
                           input logic [TW-1:0] tk);
    check(tag, "queue strobes", {rq_ins, rq_rem, sq_ins, sq_rem}, {ri, rr, si, sr});
    if (ri || rr) check(tag, "rq tid", rq_tid, IW'(tid));
    if (si || sr) check(tag, "sq tid", sq_tid, IW'(tid));
    if (ri) check(tag, "rq key", rq_key, key);
    if (si) check(tag, "sq ticks", sq_ticks, tk);
  endtask

  // Issue one command, predict every output from the model, then update the model.
  task automatic issue(input int op, input int tid, input logic [31:0] d);
    bit bad = 0, two = 0;
    bit ri1 = 0, rr1 = 0, si1 = 0, sr1 = 0, ri2 = 0, si2 = 0;
    logic [TW-1:0] k1 = '0, k2 = '0, t1 = '0, t2 = '0;
    int np, nper, sel;
    string tag;
    tag = tag_of(op);
    sel = int'(d[31:30]);
    np = m_prio[tid];
    nper = m_period[tid];
    if (op >= 1 && op <= 7 && !m_used[tid]) begin
      bad = 1; tag = "R3";
    end else begin
      case (op)
        0: if (m_used[tid]) bad = 1;
           else begin ri1 = 1; k1 = exp_key(int'(d[3:0]), int'(d[15:4])); end
        1: if (sel == 3) bad = 1;
           else begin
             two = 1; rr1 = !m_susp[tid];
             if (sel == 0) np = int'(d[3:0]);
             else if (sel == 1) nper = int'(d[11:0]);
             ri2 = !m_susp[tid]; k2 = exp_key(np, nper);
           end
        2: if (m_susp[tid]) bad = 1;
           else begin two = 1; rr1 = 1; si2 = 1; t2 = d[11:0]; end
        3: if (m_susp[tid]) bad = 1;
           else begin rr1 = 1; si1 = 1; t1 = TW'(m_period[tid]); end
        4: if (m_susp[tid]) bad = 1;
           else begin rr1 = 1; si1 = 1; t1 = TW'(1); end
        5: if (m_susp[tid]) bad = 1;
           else begin rr1 = 1; sr1 = 1; end
        6: if (!m_susp[tid]) bad = 1;
           else begin ri1 = 1; k1 = exp_key(m_prio[tid], m_period[tid]); end
        7: begin rr1 = 1; sr1 = 1; end
        8: if (d[1:0] == 2'd3) bad = 1;
        9, 10: ;
        default: bad = 1;
      endcase
    end
    @(negedge clk);
    cmd_wr = 1'b1; cmd_op = 4'(op); cmd_tid = IW'(tid); cmd_data = d;
    @(negedge clk);
    cmd_wr = 1'b0;
    check("R13", "err", err, bad);
    check("R5", "busy", busy, two);
    check({"R1/", tag}, "first cycle", 0, 0);
    checks--; // label-only line above is not a real comparison
    check_req(tag, tid, ri1, rr1, si1, sr1, k1, t1);
    if (two) begin
      @(negedge clk);
      check("R5", "busy end", busy, 0);
      check_req(tag, tid, ri2, 0, si2, 0, k2, t2);
    end
    if (!bad) begin
      case (op)
        0: begin m_used[tid] = 1; m_susp[tid] = 0;
                 m_prio[tid] = int'(d[3:0]); m_period[tid] = int'(d[15:4]); end
        1: begin m_prio[tid] = np; m_period[tid] = nper; end
        5: m_susp[tid] = 1;
        6: m_susp[tid] = 0;
        7: begin m_used[tid] = 0; m_susp[tid] = 0; end
        8: m_disc = int'(d[1:0]);
        default: ;
      endcase
    end
  endtask

  function automatic logic [31:0] mk(input int p, input int per, input int wc);
    return {2'b00, 1'b1, 1'b0, 12'(wc), 12'(per), 4'(p)};
  endfunction

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      m_now = m_now + TW'(1);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NT; i++) begin
      m_used[i] = 0; m_susp[i] = 0; m_prio[i] = 0; m_period[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check("R12", "busy", busy, 0);
    check("R12", "err", err, 0);
    check("R12", "disc", disc, 0);
    check("R12", "cur_vld/switch", {cur_vld, sw}, 2'b00);
    check("R12", "strobes", {rq_ins, rq_rem, sq_ins, sq_rem}, 4'b0000);

    // R2 create, duplicate create; R3 unused ID and bad opcode
    issue(0, 3, mk(5, 100, 20));
    issue(0, 3, mk(1, 50, 10));
    issue(1, 9, 32'h0000_0007);
    issue(12, 3, 32'h0);
    issue(15, 3, 32'h0);
    // R7 sleeps
    issue(3, 3, 32'h0);
    issue(4, 3, 32'h0);
    issue(2, 3, 32'd40);
    // R8 suspend/resume and illegal repeats
    issue(5, 3, 32'h0);
    issue(5, 3, 32'h0);
    issue(4, 3, 32'h0);
    issue(2, 3, 32'd9);
    issue(6, 3, 32'h0);
    issue(6, 3, 32'h0);
    // R4 modify priority, period, wcet, bad selector; modify while suspended
    issue(1, 3, {2'd0, 30'd2});
    issue(1, 3, {2'd1, 30'd300});
    issue(1, 3, {2'd2, 30'd77});
    issue(1, 3, {2'd3, 30'd1});
    issue(5, 3, 32'h0);
    issue(1, 3, {2'd0, 30'd9});
    issue(6, 3, 32'h0);
    // R10 disciplines
    issue(8, 0, 32'd2);
    check("R10", "disc rm", disc, 2);
    issue(5, 3, 32'h0);
    issue(6, 3, 32'h0);
    issue(8, 0, 32'd1);
    pulse_tick(5);
    issue(5, 3, 32'h0);
    issue(6, 3, 32'h0);
    issue(8, 0, 32'd3);
    check("R10", "disc kept after bad configure", disc, 1);
    issue(0, 4, mk(6, 4094, 3));
    issue(8, 0, 32'd0);

    // R6 write during busy cycle: DELETE must be dropped, MODIFY completes
    @(negedge clk);
    cmd_wr = 1'b1; cmd_op = 4'd1; cmd_tid = 4'd3; cmd_data = {2'd0, 30'd7};
    @(negedge clk);
    cmd_op = 4'd7;
    check("R6", "busy", busy, 1);
    check_req("R6", 3, 0, 1, 0, 0, '0, '0);
    @(negedge clk);
    cmd_wr = 1'b0;
    check("R6", "err on busy write", err, 1);
    check_req("R6", 3, 1, 0, 0, 0, TW'(7), '0);
    m_prio[3] = 7;
    issue(5, 3, 32'h0);   // succeeds only if task 3 survived
    issue(6, 3, 32'h0);   // key 7 shows the modify completed

    // R9 delete, then operations on freed ID, then re-create
    issue(7, 3, 32'h0);
    issue(5, 3, 32'h0);
    issue(0, 3, mk(11, 60, 5));

    // R12 / R11 current task
    head_vld = 1'b1; head_tid = 4'd2;
    repeat (2) @(negedge clk);
    check("R12", "no task while stopped", {cur_vld, sw}, 2'b00);
    issue(9, 0, 32'h0);
    @(negedge clk);
    check("R11", "first select", {cur_vld, sw, cur_tid}, {2'b11, 4'd2});
    head_tid = 4'd2;
    @(negedge clk);
    check("R11", "same head no switch", {cur_vld, sw, cur_tid}, {2'b10, 4'd2});
    head_tid = 4'd6;
    @(negedge clk);
    check("R11", "new head", {cur_vld, sw, cur_tid}, {2'b11, 4'd6});
    head_vld = 1'b0;
    @(negedge clk);
    check("R11", "empty head holds", {cur_vld, sw, cur_tid}, {2'b10, 4'd6});
    head_vld = 1'b1;
    issue(10, 0, 32'h0);
    head_tid = 4'd9;
    repeat (2) @(negedge clk);
    check("R12", "stopped holds", {cur_vld, sw, cur_tid}, {2'b10, 4'd6});
    head_vld = 1'b0;

    // random mix
    for (int n = 0; n < 500; n++) begin
      int op, tid;
      logic [31:0] d;
      op  = int'($urandom_range(0, 12));
      tid = int'($urandom_range(0, 5));
      d   = $urandom;
      if (op == 8) d[1:0] = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) pulse_tick(1);
      issue(op, tid, d);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule